// File: doc/BRIEF.md
# Exponentiation control unit

This block sequences a modular multiplier and its operand store for two kinds of job. A single job runs one modular multiplication of two stored operands. An exponent job computes a dual-base power g0^e0 · g1^e1 by a left-to-right square-and-multiply scan. The multiplier datapath and the operand memory sit outside the block. The block only names operand slots, strobes the multiplier and waits for its done pulse.

The two exponents reach the block through a 32-bit FIFO with first-word-fall-through behaviour. Each entry holds a 16-bit slice of e0 in its low half and the matching slice of e1 in its high half. The least significant slice is pushed first. The block gathers all slices into an internal buffer before it starts scanning from the top bit.

Each bit pair (e1 bit, e0 bit) always gives a squaring of the accumulator. A non-zero pair then gives a multiply by the matching pre-stored base: g0, g1 or the product g0·g1.

Operand slots:

| Code | Slot |
|------|------|
| 0 | g0 |
| 1 | g1 |
| 2 | g0·g1 |
| 3 | accumulator |

Every result is written back to the accumulator slot by the memory side.

Top module: `expo_ctrl`

## Requirements
- R1: After reset, `ready`, `calc_time`, `mul_start`, `x_load` and `fifo_pop` are low, and `mul_part` is 2'b11.
- R2: Each multiplication is issued as follows. `x_load` is high for one cycle with `x_sel` naming the x slot. In the next cycle `mul_start` is high for one cycle with `y_sel` naming the y slot. A single job (`mode_exp`=0) issues exactly one multiplication, with x slot 0 and y slot 1.
- R3: `calc_time` is high from the cycle in which `mul_start` is high, through the cycle in which `mul_done` is high, inclusive. It is low in every other cycle.
- R4: An exponent job (`mode_exp`=1) pops the FIFO only in cycles when `fifo_empty` is low. It pops exactly N_WORDS entries, and issues no multiplication until the last entry has been taken. While the FIFO is empty, the block waits.
- R5: The k-th popped entry (k from 0) supplies bits [16k+15:16k] of e0 from entry bits [15:0], and the same bits of e1 from entry bits [31:16].
- R6: The scan runs from exponent bit N_WORDS*16-1 down to bit 0. For each bit it issues a squaring with x slot 3 and y slot 3. If the pair {e1 bit, e0 bit} is non-zero, a multiply follows, with x slot 3 and y slot 0 for pair 01, slot 1 for pair 10, and slot 2 for pair 11.
- R7: `ready` goes high in the cycle after the edge at which the final `mul_done` is sampled. It stays high until an accepted start, and it is low from the edge at which a start is accepted.
- R8: A `start` pulse while a job is in progress is ignored. The running job's multiplication sequence is unchanged, and `ready` stays low.
- R9: A `start` with `part_sel`=2'b00 is ignored. An accepted start copies `part_sel` to `mul_part`, which holds that value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch a job in the selected mode |
| mode_exp | input | 1 | 0: single multiplication, 1: exponent job |
| part_sel | input | 2 | Multiplier part: 01 low, 10 high, 11 full; 00 is invalid |
| fifo_data | input | 32 | Head entry of the exponent FIFO ({e1 slice, e0 slice}) |
| fifo_empty | input | 1 | Exponent FIFO is empty |
| fifo_pop | output | 1 | Take the head entry of the FIFO |
| mul_done | input | 1 | Multiplier has finished the current product |
| x_load | output | 1 | Latch the x operand from slot `x_sel` |
| x_sel | output | 2 | Slot code of the x operand |
| mul_start | output | 1 | Start the multiplier with y from slot `y_sel` |
| y_sel | output | 2 | Slot code of the y operand |
| mul_part | output | 2 | Multiplier part latched for the current job |
| ready | output | 1 | Last job has finished |
| calc_time | output | 1 | High while a multiplication is running |

## Verification
The hardest situation to reach is an exponent job that has started while its FIFO is still empty or only partly filled. The block must then wait without issuing work and assemble the slices in arrival order. The bench launches the job with no entries queued and holds the FIFO empty for many cycles. It then feeds one slice, waits again, and confirms that no multiplication has started. Only then does it release the top slice.

The exponent patterns are chosen so that the low and high slices carry different pair mixes. A swapped slice order or a swapped half would then change the observed slot sequence. A start pulse is also injected in the middle of a long scan to show that the sequence does not change.

// File: rtl/expo_pkg.sv
package expo_pkg;

   // operand slot codes seen by the operand memory
   typedef enum logic [1:0] {
      SLOT_G0  = 2'd0,
      SLOT_G1  = 2'd1,
      SLOT_G01 = 2'd2,
      SLOT_ACC = 2'd3
   } slot_e;

   // job-level states
   typedef enum logic [1:0] {
      M_IDLE,
      M_GATHER,
      M_ISSUE,
      M_BUSY
   } main_st_e;

   // per-product handshake states
   typedef enum logic [1:0] {
      S_IDLE,
      S_LDX,
      S_GO,
      S_WAIT
   } seq_st_e;

   // which product the job issues next
   typedef enum logic [1:0] {
      PH_SINGLE,
      PH_SQR,
      PH_MUL
   } phase_e;

endpackage

// File: rtl/expo_word_buf.sv
module expo_word_buf #(
   parameter int HALF_W  = 16,
   parameter int N_WORDS = 2,
   localparam int WORD_W   = 2 * HALF_W,
   localparam int EXP_BITS = N_WORDS * HALF_W,
   localparam int IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
   localparam int BIT_W    = (EXP_BITS > 1) ? $clog2(EXP_BITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [BIT_W-1:0]  rd_idx,
   output logic [1:0]        rd_pair
);

   logic [EXP_BITS-1:0] e0_flat;
   logic [EXP_BITS-1:0] e1_flat;

   initial begin
      assert (HALF_W >= 1) else $error("expo_word_buf: HALF_W must be at least 1");
      assert (N_WORDS >= 1) else $error("expo_word_buf: N_WORDS must be at least 1");
   end

   // one slice register pair per FIFO entry; entry k lands at bit 16k upward
   for (genvar k = 0; k < N_WORDS; k++) begin : g_word
      logic [HALF_W-1:0] lo_q;
      logic [HALF_W-1:0] hi_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
         end else if (wr_en && (wr_idx == IDX_W'(k))) begin
            lo_q <= wr_word[HALF_W-1:0];
            hi_q <= wr_word[WORD_W-1:HALF_W];
         end
      end

      assign e0_flat[k*HALF_W +: HALF_W] = lo_q;
      assign e1_flat[k*HALF_W +: HALF_W] = hi_q;
   end

   assign rd_pair = {e1_flat[rd_idx], e0_flat[rd_idx]};

   AST_WR_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (int'(wr_idx) < N_WORDS)); // R5

endmodule

// File: rtl/expo_mul_seq.sv
module expo_mul_seq
   import expo_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       go,
   input  logic [1:0] go_x,
   input  logic [1:0] go_y,
   input  logic       mul_done,
   output logic       x_load,
   output logic [1:0] x_sel,
   output logic       mul_start,
   output logic [1:0] y_sel,
   output logic       calc_time,
   output logic       fin
);

   seq_st_e    st;
   logic [1:0] xs_q;
   logic [1:0] ys_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         xs_q <= 2'd0;
         ys_q <= 2'd0;
      end else begin
         case (st)
            S_IDLE: if (go) begin
               xs_q <= go_x;
               ys_q <= go_y;
               st   <= S_LDX;
            end
            S_LDX:  st <= S_GO;
            S_GO:   st <= S_WAIT;
            S_WAIT: if (mul_done) st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign x_load    = (st == S_LDX);
   assign mul_start = (st == S_GO);
   assign calc_time = (st == S_GO) || (st == S_WAIT);
   assign fin       = (st == S_WAIT) && mul_done;
   assign x_sel     = xs_q;
   assign y_sel     = ys_q;

   AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      mul_start |-> $past(x_load)); // R2
   AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({x_load, mul_start})); // R2
   AST_CALC_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (calc_time && mul_done) |=> !calc_time); // R3
   AST_CALC_FROM_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(calc_time) |-> mul_start); // R3

endmodule

// File: rtl/expo_part_sel.sv
module expo_part_sel #(
   parameter bit SPLIT = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       capture,
   input  logic [1:0] part_in,
   output logic       part_ok,
   output logic [1:0] part_q
);

   if (SPLIT) begin : g_split
      logic [1:0] q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= 2'b11;
         else if (capture) q <= part_in;
      end

      assign part_ok = |part_in;
      assign part_q  = q;
   end else begin : g_full
      // single undivided multiplier: every start is valid, full width always
      assign part_ok = 1'b1;
      assign part_q  = 2'b11;
   end

endmodule

// File: rtl/expo_ctrl.sv
module expo_ctrl
   import expo_pkg::*;
#(
   parameter int HALF_W  = 16,
   parameter int N_WORDS = 2,
   parameter bit SPLIT   = 1'b1,
   localparam int WORD_W   = 2 * HALF_W,
   localparam int EXP_BITS = N_WORDS * HALF_W,
   localparam int IDX_W    = (N_WORDS > 1) ? $clog2(N_WORDS) : 1,
   localparam int BIT_W    = (EXP_BITS > 1) ? $clog2(EXP_BITS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              mode_exp,
   input  logic [1:0]        part_sel,
   input  logic [WORD_W-1:0] fifo_data,
   input  logic              fifo_empty,
   output logic              fifo_pop,
   input  logic              mul_done,
   output logic              x_load,
   output logic [1:0]        x_sel,
   output logic              mul_start,
   output logic [1:0]        y_sel,
   output logic [1:0]        mul_part,
   output logic              ready,
   output logic              calc_time
);

   main_st_e         st;
   phase_e           phase;
   logic [IDX_W-1:0] wcnt;
   logic [BIT_W-1:0] bit_idx;
   logic [1:0]       pair;
   logic             part_ok;
   logic             accept;
   logic             go;
   logic [1:0]       go_x;
   logic [1:0]       go_y;
   logic             fin;

   initial begin
      assert (EXP_BITS <= 4096) else $error("expo_ctrl: exponent buffer too large");
      assert ((EXP_BITS & (EXP_BITS - 1)) == 0)
         else $error("expo_ctrl: N_WORDS*HALF_W must be a power of two");
   end

   assign accept   = start && (st == M_IDLE) && part_ok;
   assign fifo_pop = (st == M_GATHER) && !fifo_empty;
   assign go       = (st == M_ISSUE);

   always_comb begin
      go_x = SLOT_ACC;
      go_y = SLOT_ACC;
      case (phase)
         PH_SINGLE: begin
            go_x = SLOT_G0;
            go_y = SLOT_G1;
         end
         PH_MUL:  go_y = 2'(pair - 2'd1);
         default: go_y = SLOT_ACC;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= M_IDLE;
         phase   <= PH_SINGLE;
         wcnt    <= '0;
         bit_idx <= '0;
         ready   <= 1'b0;
      end else begin
         case (st)
            M_IDLE: if (accept) begin
               ready <= 1'b0;
               if (mode_exp) begin
                  wcnt <= '0;
                  st   <= M_GATHER;
               end else begin
                  phase <= PH_SINGLE;
                  st    <= M_ISSUE;
               end
            end
            M_GATHER: if (!fifo_empty) begin
               wcnt <= wcnt + 1'b1;
               if (wcnt == IDX_W'(N_WORDS - 1)) begin
                  bit_idx <= BIT_W'(EXP_BITS - 1);
                  phase   <= PH_SQR;
                  st      <= M_ISSUE;
               end
            end
            M_ISSUE: st <= M_BUSY;
            M_BUSY: if (fin) begin
               case (phase)
                  PH_SQR: begin
                     if (pair != 2'b00) begin
                        phase <= PH_MUL;
                        st    <= M_ISSUE;
                     end else if (bit_idx == '0) begin
                        ready <= 1'b1;
                        st    <= M_IDLE;
                     end else begin
                        bit_idx <= bit_idx - 1'b1;
                        st      <= M_ISSUE;
                     end
                  end
                  PH_MUL: begin
                     if (bit_idx == '0) begin
                        ready <= 1'b1;
                        st    <= M_IDLE;
                     end else begin
                        bit_idx <= bit_idx - 1'b1;
                        phase   <= PH_SQR;
                        st      <= M_ISSUE;
                     end
                  end
                  default: begin
                     ready <= 1'b1;
                     st    <= M_IDLE;
                  end
               endcase
            end
            default: st <= M_IDLE;
         endcase
      end
   end

   expo_word_buf #(
      .HALF_W  (HALF_W),
      .N_WORDS (N_WORDS)
   ) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (fifo_pop),
      .wr_idx  (wcnt),
      .wr_word (fifo_data),
      .rd_idx  (bit_idx),
      .rd_pair (pair)
   );

   expo_mul_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (go),
      .go_x      (go_x),
      .go_y      (go_y),
      .mul_done  (mul_done),
      .x_load    (x_load),
      .x_sel     (x_sel),
      .mul_start (mul_start),
      .y_sel     (y_sel),
      .calc_time (calc_time),
      .fin       (fin)
   );

   expo_part_sel #(
      .SPLIT (SPLIT)
   ) u_part (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (accept),
      .part_in (part_sel),
      .part_ok (part_ok),
      .part_q  (mul_part)
   );

   AST_NO_MUL_WHILE_GATHER: assert property (@(posedge clk) disable iff (!rst_n)
      (st == M_GATHER) |-> !mul_start); // R4
   AST_READY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !start) |=> ready); // R7
   AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> !calc_time); // R3
   AST_PART_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      (st != M_IDLE) |=> $stable(mul_part)); // R9
   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (st == M_BUSY)) |=> !ready); // R8

endmodule

// File: tb/sim_expo_ctrl.sv
`timescale 1ns/1ps
module sim_expo_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        mode_exp = 1'b0;
   logic [1:0]  part_sel = 2'b11;
   logic [31:0] fifo_data;
   logic        fifo_empty;
   logic        fifo_pop;
   logic        mul_done = 1'b0;
   logic        x_load;
   logic [1:0]  x_sel;
   logic        mul_start;
   logic [1:0]  y_sel;
   logic [1:0]  mul_part;
   logic        ready;
   logic        calc_time;

   always #5 clk = ~clk;

   expo_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .mode_exp(mode_exp),
      .part_sel(part_sel), .fifo_data(fifo_data), .fifo_empty(fifo_empty),
      .fifo_pop(fifo_pop), .mul_done(mul_done), .x_load(x_load), .x_sel(x_sel),
      .mul_start(mul_start), .y_sel(y_sel), .mul_part(mul_part), .ready(ready),
      .calc_time(calc_time)
   );

   // FIFO model (first word falls through)
   logic [31:0] fq [64];
   int wr_ptr = 0;
   int rd_ptr = 0;
   assign fifo_empty = (rd_ptr == wr_ptr);
   assign fifo_data  = fq[rd_ptr % 64];
   always @(posedge clk) if (fifo_pop) rd_ptr <= rd_ptr + 1;

   // observation and multiplier model
   int n_obs = 0, pops = 0, calc_err = 0, ord_err = 0;
   int obs_x [128];
   int obs_y [128];
   int ex_x [128];
   int ex_y [128];
   int n_exp = 0;
   int mcnt = 0, mlat = 3;
   bit in_mul = 0, prev_xl = 0, exp_c;
   int last_x = 0;
   int checks = 0, fails = 0;
   int cyc = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mul_start) in_mul = 1;
         exp_c = in_mul;
         if (calc_time !== exp_c) calc_err++;
         if (mul_start && !prev_xl) ord_err++;
         if (x_load) last_x = int'(x_sel);
         if (mul_start && n_obs < 128) begin
            obs_x[n_obs] = last_x;
            obs_y[n_obs] = int'(y_sel);
            n_obs++;
         end
         if (fifo_pop) pops++;
         mul_done = 1'b0;
         if (mcnt > 0) begin
            mcnt--;
            if (mcnt == 0) begin
               mul_done = 1'b1;
               in_mul = 0;
            end
         end
         if (mul_start) mcnt = mlat;
         prev_xl = x_load;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         checks++;
         $display("FAIL watchdog (all requirements): actual %0d cycles, expected fewer than 150000", cyc);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic clear_obs();
      @(negedge clk);
      n_obs = 0; pops = 0; calc_err = 0; ord_err = 0;
   endtask

   task automatic push(input logic [31:0] w);
      fq[wr_ptr % 64] = w;
      wr_ptr++;
   endtask

   task automatic push_exp(input logic [31:0] e0, input logic [31:0] e1);
      push({e1[15:0], e0[15:0]});
      push({e1[31:16], e0[31:16]});
   endtask

   task automatic do_start(input bit mode, input logic [1:0] part);
      @(negedge clk);
      mode_exp = mode;
      part_sel = part;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
   endtask

   task automatic wait_ready(output bit ok);
      ok = 0;
      for (int i = 0; i < 5000; i++) begin
         @(negedge clk);
         if (ready) begin
            ok = 1;
            break;
         end
      end
   endtask

   task automatic build_expect(input logic [31:0] e0, input logic [31:0] e1);
      logic [1:0] pr;
      n_exp = 0;
      for (int b = 31; b >= 0; b--) begin
         ex_x[n_exp] = 3; ex_y[n_exp] = 3; n_exp++;
         pr = {e1[b], e0[b]};
         if (pr != 2'b00) begin
            ex_x[n_exp] = 3; ex_y[n_exp] = int'(pr) - 1; n_exp++;
         end
      end
   endtask

   task automatic compare_seq(input string req);
      int bad;
      bad = -1;
      chk(n_obs == n_exp, {req, " product count"}, n_obs, n_exp);
      for (int i = 0; i < n_exp && i < n_obs; i++)
         if (bad < 0 && (obs_x[i] != ex_x[i] || obs_y[i] != ex_y[i])) bad = i;
      if (bad >= 0)
         chk(0, {req, " slot sequence (x*4+y at first mismatch)"},
             obs_x[bad]*4 + obs_y[bad], ex_x[bad]*4 + ex_y[bad]);
      else
         chk(1, req, 0, 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!ready && !calc_time && !mul_start && !x_load && !fifo_pop,
          "R1 reset outputs", {ready, calc_time, mul_start, x_load, fifo_pop}, 0);
      chk(mul_part == 2'b11, "R1 reset part", mul_part, 3);
   endtask

   task automatic t_single();
      bit ok;
      clear_obs();
      do_start(1'b0, 2'b11);
      wait_ready(ok);
      chk(ok, "R7 single ready", ok, 1);
      chk(n_obs == 1 && obs_x[0] == 0 && obs_y[0] == 1, "R2 single slots",
          obs_x[0]*4 + obs_y[0], 1);
      chk(ord_err == 0, "R2 load before start", ord_err, 0);
      chk(calc_err == 0, "R3 calc_time window", calc_err, 0);
      repeat (5) @(negedge clk);
      chk(ready, "R7 ready held", ready, 1);
      chk(n_obs == 1, "R2 only one product", n_obs, 1);
   endtask

   task automatic t_bad_part();
      clear_obs();
      do_start(1'b0, 2'b00);
      repeat (10) @(negedge clk);
      chk(n_obs == 0 && ready, "R9 part 00 ignored", n_obs, 0);
   endtask

   task automatic t_exp(input logic [31:0] e0, input logic [31:0] e1,
                        input logic [1:0] part, input bit poke, input string tag);
      bit ok;
      clear_obs();
      push_exp(e0, e1);
      build_expect(e0, e1);
      do_start(1'b1, part);
      chk(!ready, {"R7 ready falls ", tag}, ready, 0);
      if (poke) begin
         repeat (40) @(negedge clk);
         do_start(1'b0, 2'b11);
         chk(!ready, "R8 ready low after busy start", ready, 0);
      end
      repeat (20) @(negedge clk);
      chk(mul_part == part, {"R9 part latched ", tag}, mul_part, part);
      wait_ready(ok);
      chk(ok, {"R7 exp ready ", tag}, ok, 1);
      chk(pops == 2, {"R4 pops ", tag}, pops, 2);
      compare_seq({"R6 R5 ", tag});
      chk(calc_err == 0 && ord_err == 0, {"R3 R2 handshake ", tag}, calc_err + ord_err, 0);
   endtask

   task automatic t_stall();
      bit ok;
      logic [31:0] e0 = 32'h8001_0002;
      logic [31:0] e1 = 32'h0003_4000;
      clear_obs();
      build_expect(e0, e1);
      do_start(1'b1, 2'b10);
      repeat (20) @(negedge clk);
      chk(pops == 0 && n_obs == 0, "R4 wait on empty FIFO", pops + n_obs, 0);
      push({e1[15:0], e0[15:0]});
      repeat (10) @(negedge clk);
      chk(pops == 1, "R4 one slice taken", pops, 1);
      chk(n_obs == 0, "R4 no product before last slice", n_obs, 0);
      push({e1[31:16], e0[31:16]});
      wait_ready(ok);
      chk(ok && pops == 2, "R4 stall job completes", pops, 2);
      compare_seq("R5 R6 stalled job");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_single();
      t_bad_part();
      t_exp(32'h0000_0005, 32'h8000_0003, 2'b11, 1'b0, "mixed");
      t_exp(32'h1234_00F0, 32'h00F0_5678, 2'b01, 1'b1, "busy-start");
      t_exp(32'h0000_0000, 32'h0000_0000, 2'b10, 1'b0, "zero");
      mlat = 1;
      t_exp(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2'b11, 1'b0, "ones");
      mlat = 5;
      t_stall();
      t_single();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule